// File: doc/BRIEF.md
# DRAM Refresh Sequencer

This block decides when a DRAM array is refreshed and shapes each refresh cycle. In normal operation an internal interval timer raises a refresh request every `INTERVAL` clocks. The request stays pending until no access RAS is active, and then the refresh runs. Software or a board controller can switch the timer off with `refresh_inhibit` and drive refreshes itself through `ext_refresh`. A single pulse gives one refresh. Holding the input high gives back-to-back refreshes until it is released.

Each refresh has three phases:
- a one-clock lead-in, where only `refresh_in_progress` is raised;
- a RAS-low phase, where every bank strobe is driven together;
- a precharge phase, which keeps `hold_access` high so that the host arbiter cannot start an access RAS too early.

A 2-bit timing code sets the lengths of the RAS-low and precharge phases. A row counter advances after every refresh. Pulsing `ext_refresh` while the timer is enabled clears the row counter, which lets a burst refresh start from row zero.

Top module: `dram_refresh_sequencer`

## Requirements
- R1: With `refresh_inhibit` low, the timer requests a refresh every `INTERVAL` clocks. A request that cannot start at once stays pending until it does.
- R2: `refresh_in_progress` rises one clock before the bank strobes rise. It falls in the same clock as the strobes fall.
- R3: With `refresh_inhibit` high, the timer starts no refresh, and any pending timer request is dropped.
- R4: With `refresh_inhibit` high, a one-clock `ext_refresh` pulse gives exactly one refresh. Holding `ext_refresh` high gives back-to-back refreshes until it is released.
- R5: `ext_refresh` high while `refresh_inhibit` is low sets `refresh_row` to 0 one clock later and starts no refresh.
- R6: `timing_code` is sampled when a refresh starts and sets the RAS-low and precharge lengths in clocks:
  - 00 gives 2 clocks low and 1 clock precharge;
  - 01 gives 3 and 2;
  - 10 gives 2 and 2;
  - 11 gives 4 and 3.
- R7: `hold_access` is high from the lead-in clock to the last precharge clock, inclusive, and low otherwise.
- R8: `refresh_row` is 0 after reset. It increments by one when the RAS-low phase of each refresh ends, and wraps at 2^`ROW_W`.
- R9: A refresh starts only in a clock where `access_ras_active` is low. Once started, it runs to its end whatever the inputs do.
- R10: All `BANKS` bits of `refresh_ras` are driven with one value and are active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timing_code | input | 2 | RAS-low and precharge length select |
| refresh_inhibit | input | 1 | Disables the interval timer and enables external requests |
| ext_refresh | input | 1 | External refresh request, or row-counter clear when the timer is enabled |
| access_ras_active | input | 1 | An access RAS is currently asserted by the host side |
| refresh_in_progress | output | 1 | Refresh lead-in and RAS-low phases |
| hold_access | output | 1 | Host accesses must not start a RAS |
| refresh_ras | output | BANKS | Refresh RAS strobe for every bank, active high |
| refresh_row | output | ROW_W | Current refresh row |

## Verification
The hardest situation to bring about is a timer request that expires while the host holds an access RAS. The request must stay latched and fire only after the access ends. The stimulus holds `access_ras_active` high across more than one full interval, then releases it. It expects exactly one delayed refresh, followed by refreshes spaced exactly `INTERVAL` apart. Row wrap is reached with a narrow row counter and a held external burst of 18 refreshes.

// File: rtl/dram_refresh_sequencer.sv
module dram_refresh_sequencer #(
  parameter int ROW_W    = 10,
  parameter int INTERVAL = 390,
  parameter int BANKS    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       timing_code,
  input  logic             refresh_inhibit,
  input  logic             ext_refresh,
  input  logic             access_ras_active,
  output logic             refresh_in_progress,
  output logic             hold_access,
  output logic [BANKS-1:0] refresh_ras,
  output logic [ROW_W-1:0] refresh_row
);
  localparam int TMR_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

  typedef enum logic [1:0] {IDLE, LEAD, LOW, PRE} phase_t;

  phase_t           phase;
  logic [TMR_W-1:0] tmr;
  logic             pend;
  logic [1:0]       code_q;
  logic [2:0]       cnt;
  logic [2:0]       low_len, pre_len;
  logic             expire, start;

  always_comb begin
    case (code_q)
      2'b00:   begin low_len = 3'd2; pre_len = 3'd1; end
      2'b01:   begin low_len = 3'd3; pre_len = 3'd2; end
      2'b10:   begin low_len = 3'd2; pre_len = 3'd2; end
      default: begin low_len = 3'd4; pre_len = 3'd3; end
    endcase
  end

  assign expire = !refresh_inhibit && (tmr == TMR_W'(INTERVAL - 1));
  assign start  = (phase == IDLE) && !access_ras_active &&
                  (refresh_inhibit ? ext_refresh : pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr  <= '0;
      pend <= 1'b0;
    end else if (refresh_inhibit) begin
      tmr  <= '0;
      pend <= 1'b0;
    end else begin
      tmr  <= expire ? '0 : tmr + 1'b1;
      pend <= expire || (pend && !start);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= IDLE;
      cnt    <= '0;
      code_q <= 2'b00;
    end else begin
      case (phase)
        IDLE: if (start) begin
          phase  <= LEAD;
          code_q <= timing_code;
        end
        LEAD: begin
          phase <= LOW;
          cnt   <= low_len - 3'd1;
        end
        LOW: if (cnt == 3'd0) begin
          phase <= PRE;
          cnt   <= pre_len - 3'd1;
        end else cnt <= cnt - 3'd1;
        default: if (cnt == 3'd0) phase <= IDLE;
                 else cnt <= cnt - 3'd1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             refresh_row <= '0;
    else if (ext_refresh && !refresh_inhibit) refresh_row <= '0;
    else if (phase == LOW && cnt == 3'd0)   refresh_row <= refresh_row + 1'b1;
  end

  assign refresh_in_progress = (phase == LEAD) || (phase == LOW);
  assign hold_access         = (phase != IDLE);
  assign refresh_ras         = {BANKS{phase == LOW}};
endmodule

// File: rtl/refresh_seq_chk.sv
module refresh_seq_chk #(
  parameter int ROW_W = 10,
  parameter int BANKS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             refresh_inhibit,
  input logic             ext_refresh,
  input logic             access_ras_active,
  input logic             refresh_in_progress,
  input logic             hold_access,
  input logic [BANKS-1:0] refresh_ras,
  input logic [ROW_W-1:0] refresh_row
);
  // R2
  rip_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|refresh_ras) |-> $past(refresh_in_progress));
  // R2
  rip_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|refresh_ras) |-> !refresh_in_progress);
  // R3
  inhibit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(refresh_in_progress) && $past(refresh_inhibit)) |-> $past(ext_refresh));
  // R5
  row_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_refresh && !refresh_inhibit) |=> (refresh_row == '0));
  // R7
  hold_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_in_progress || (|refresh_ras)) |-> hold_access);
  // R9
  grant_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refresh_in_progress) |-> !$past(access_ras_active));
  // R10
  banks_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_ras == '0) || (&refresh_ras));
endmodule

bind dram_refresh_sequencer refresh_seq_chk #(.ROW_W(ROW_W), .BANKS(BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .refresh_inhibit(refresh_inhibit),
  .ext_refresh(ext_refresh), .access_ras_active(access_ras_active),
  .refresh_in_progress(refresh_in_progress), .hold_access(hold_access),
  .refresh_ras(refresh_ras), .refresh_row(refresh_row)
);

// File: tb/test_dram_refresh_sequencer.sv
module test_dram_refresh_sequencer;
  localparam int ROW_W = 4, INTERVAL = 40, BANKS = 4;

  logic clk = 0, rst_n = 0;
  logic [1:0] timing_code = 2'b00;
  logic refresh_inhibit = 1, ext_refresh = 0, access_ras_active = 0;
  logic rip, hold;
  logic [BANKS-1:0] ras;
  logic [ROW_W-1:0] row;

  always #2.5 clk = ~clk;

  dram_refresh_sequencer #(.ROW_W(ROW_W), .INTERVAL(INTERVAL), .BANKS(BANKS)) i_dram_refresh_sequencer (
    .clk(clk), .rst_n(rst_n), .timing_code(timing_code),
    .refresh_inhibit(refresh_inhibit), .ext_refresh(ext_refresh),
    .access_ras_active(access_ras_active), .refresh_in_progress(rip),
    .hold_access(hold), .refresh_ras(ras), .refresh_row(row));

  typedef struct { int row; int lo; int pr; } item_t;
  item_t q[$];
  int checks = 0, fails = 0, rises = 0, done = 0, cyc = 0, exp_row = 0;
  int rise_at[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_refresh(input int code);
    item_t it;
    it.row = exp_row;
    it.lo  = (code == 1) ? 3 : (code == 3) ? 4 : 2;
    it.pr  = (code == 0) ? 1 : (code == 3) ? 3 : 2;
    q.push_back(it);
    exp_row = (exp_row + 1) % (1 << ROW_W);
  endtask

  task automatic wait_done(input int target);
    int n = 0;
    while (done < target && n < 3000) begin @(posedge clk); n++; end
    if (done < target) chk(0, "R4 refresh count", done, target);
  endtask

  // monitor
  int mph = 0, lowc = 0, prec = 0;
  bit rip_prev = 0;
  item_t cur;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      case (mph)
        0: if (|ras) begin
          rises++;
          rise_at.push_back(cyc);
          chk(&ras, "R10 all banks", int'(ras), (1 << BANKS) - 1);
          chk(rip_prev, "R2 lead-in", rip_prev, 1);
          if (q.size() == 0) chk(0, "R4 unexpected refresh", rises, 0);
          else begin
            cur = q.pop_front();
            chk(int'(row) == cur.row, "R8 row", row, cur.row);
          end
          lowc = 1; mph = 1;
        end
        1: if (|ras) lowc++;
        else begin
          chk(lowc == cur.lo, "R6 low length", lowc, cur.lo);
          chk(!rip, "R2 rip drop", rip, 0);
          chk(hold, "R7 hold in precharge", hold, 1);
          prec = 1; mph = 2;
        end
        default: if (hold) prec++;
        else begin
          chk(prec == cur.pr, "R6 precharge length", prec, cur.pr);
          done++; mph = 0;
        end
      endcase
    end
    rip_prev = rip;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    tick(5);
    rst_n = 1;
    tick(1);
    chk(!rip && !hold && ras == 0, "R7 reset idle", {rip, hold}, 0);
    chk(row == 0, "R8 reset row", row, 0);

    // R4 single pulses, R6 every code
    for (int c = 0; c < 4; c++) begin
      timing_code = 2'(c);
      expect_refresh(c);
      ext_refresh = 1; tick(1); ext_refresh = 0;
      wait_done(c + 1);
      tick(3);
    end

    // R9 blocked by an access, then released
    access_ras_active = 1; ext_refresh = 1; timing_code = 2'b11;
    tick(20);
    chk(rises == 4 && !rip, "R9 no start during access", rises, 4);
    expect_refresh(3);
    access_ras_active = 0;
    while (rises < 5) tick(1);
    ext_refresh = 0;
    wait_done(5);
    tick(3);

    // R4 held burst, R8 wrap
    timing_code = 2'b00;
    for (int i = 0; i < 18; i++) expect_refresh(0);
    ext_refresh = 1;
    while (rises < 23) tick(1);
    ext_refresh = 0;
    wait_done(23);
    tick(5);
    chk(rises == 23, "R4 burst stops on release", rises, 23);
    chk(row == 7, "R8 wrap", row, 7);

    // R5 clear
    refresh_inhibit = 0; ext_refresh = 1; tick(1);
    refresh_inhibit = 1; ext_refresh = 0;
    chk(row == 0, "R5 row cleared", row, 0);
    exp_row = 0;
    tick(10);
    chk(rises == 23, "R5 no refresh from clear", rises, 23);

    // R3 timer off
    tick(3 * INTERVAL);
    chk(rises == 23, "R3 inhibit", rises, 23);

    // R1 latched timer request behind an access
    timing_code = 2'b01;
    access_ras_active = 1; refresh_inhibit = 0;
    tick(60);
    chk(rises == 23, "R9 timer held by access", rises, 23);
    expect_refresh(1); expect_refresh(1); expect_refresh(1);
    access_ras_active = 0;
    wait_done(26);
    refresh_inhibit = 1;
    chk(rise_at[25] - rise_at[24] == INTERVAL, "R1 interval",
        rise_at[25] - rise_at[24], INTERVAL);
    tick(3 * INTERVAL);
    chk(rises == 26, "R3 inhibit after timer", rises, 26);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule